// File: doc/BRIEF.md
# SDRAM Controller Configuration Register File

This block holds the two 32-bit configuration words that software programs to steer an SDRAM controller's command engine. It sits behind a simple register bus with a word address, a write strobe, write data and read data. It turns the stored bits into named, decoded fields for the engine: the latency settings, data bus width, clock and clock-enable policy, command standard, per-chip-select bank count and address mode, buffer enables, and the initialization command selector.

Beyond plain storage, some writes have timed side effects. Turning off the merging write buffer raises a one-clock flush request. Writing a NOP or precharge-all initialization code raises a one-clock request each time that code is written. The engine's busy level shows live in the second word. While the engine is busy, writes to the first word are refused, and the refusal is recorded in a sticky error flag. A reserved latency code of 00 is kept as written but decodes to three cycles.

Top module: `sdram_cfg_regs`

## Requirements
- R1: After reset, word 0 (address 0) reads 32'h01F0_0000 and word 1 (address 1) reads 32'h0000_0018 with busy low. Both latencies decode to 3. Auto-precharge, write buffer and background restore are 1. All other outputs are 0.
- R2: The RAS-to-CAS code (word 0 bits 23:22) and the CAS code (bits 21:20) decode 01→1, 10→2 and 11→3 cycles. The reserved code 00 decodes to 3 but reads back as 00.
- R3: Chip select i takes its four-bank flag from word 0 bit 4i+3 and its x8 address-mode flag from bit 4i+2.
- R4: Word 0 single-bit flags: bit 25 command standard, bit 24 auto-precharge, bit 19 half-width bus, bit 18 clock enable held high, bit 17 clock stop when idle, bit 16 virtual-channel mode.
- R5: Reserved bits always read 0: word 0 bits 31:26, 13, 12, 9, 8, 5, 4, 1, 0, and word 1 bits 31:6.
- R6: Word 1 bit 5 reads the live engine busy input. Writes to it have no effect.
- R7: A word 0 write while engine_busy is high leaves word 0 unchanged and sets cfg_wr_err. cfg_wr_err stays set until reset.
- R8: Word 1 bit 4 drives background restore, bit 3 the write buffer enable and bit 2 the read buffer enable. Word 1 writes are accepted while busy.
- R9: wbuf_flush is high for exactly the one cycle after a word 1 write that changes bit 3 from 1 to 0. A write of 0 to an already-clear bit 3 gives no pulse.
- R10: The init code is {bit 1 = M, bit 0 = I} of word 1. Code 11 gives a one-cycle req_nop and code 01 a one-cycle req_pall, in the cycle after each such write, repeated writes included. Code 10 holds cmd_mode high while stored. Code 00 is normal operation.
- R11: Addresses other than 0 and 1 read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | ADDR_W | Word address |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| engine_busy | input | 1 | Command engine busy level |
| ras_lat | output | 2 | RAS-to-CAS latency in cycles |
| cas_lat | output | 2 | CAS latency in cycles |
| auto_pchg | output | 1 | Auto-precharge enable |
| cmd_std | output | 1 | Alternate command standard select |
| bus_half | output | 1 | Half-width external bus |
| cke_always | output | 1 | Clock enables held high |
| clk_stop | output | 1 | Stop memory clock when idle |
| vc_mode | output | 1 | Virtual-channel mode |
| cs_four_bank | output | NUM_CS | Four-bank device per chip select |
| cs_x8 | output | NUM_CS | x8 address mode per chip select |
| bg_restore_en | output | 1 | Background restore enable |
| wbuf_en | output | 1 | Merging write buffer enable |
| rbuf_en | output | 1 | Read buffer enable |
| cmd_mode | output | 1 | Command mode active |
| wbuf_flush | output | 1 | One-cycle write buffer flush request |
| req_nop | output | 1 | One-cycle NOP request |
| req_pall | output | 1 | One-cycle precharge-all request |
| cfg_wr_err | output | 1 | Sticky refused-write flag |

## Verification
The bench builds the block with NUM_CS = 4 and ADDR_W = 2, the default values. Four chip selects cover every interleaved bank and mode bit position in word 0. The two-bit address adds two unmapped word slots, so the rule for addresses that decode to no register can be tested. With these settings, every field of both words and every init code can be reached through the register bus.

// File: rtl/sdram_cfg_pkg.sv
package sdram_cfg_pkg;

  localparam int unsigned REG_W = 32;

  // writable bits and reset image of each word
  localparam logic [REG_W-1:0] W0_MASK  = 32'h03FF_CCCC;
  localparam logic [REG_W-1:0] W0_RESET = 32'h01F0_0000;
  localparam int unsigned      W1_BITS  = 5;
  localparam logic [W1_BITS-1:0] W1_RESET = 5'b11000;

  // word 0 field positions
  localparam int unsigned B_STD   = 25;
  localparam int unsigned B_APCH  = 24;
  localparam int unsigned B_RC_HI = 23;
  localparam int unsigned B_CL_HI = 21;
  localparam int unsigned B_HALF  = 19;
  localparam int unsigned B_CKE   = 18;
  localparam int unsigned B_CSTOP = 17;
  localparam int unsigned B_VC    = 16;

  // word 1 field positions
  localparam int unsigned B_BUSY  = 5;
  localparam int unsigned B_BGR   = 4;
  localparam int unsigned B_WBUF  = 3;
  localparam int unsigned B_RBUF  = 2;

  // {M, I}
  typedef enum logic [1:0] {
    INIT_NORMAL  = 2'b00,
    INIT_PALL    = 2'b01,
    INIT_CMDMODE = 2'b10,
    INIT_NOP     = 2'b11
  } init_cmd_e;

  function automatic logic [1:0] lat_cycles(input logic [1:0] code);
    return (code == 2'b00) ? 2'd3 : code;
  endfunction

  function automatic int unsigned bank_bit(input int unsigned cs);
    return 4 * cs + 3;
  endfunction

  function automatic int unsigned mode_bit(input int unsigned cs);
    return 4 * cs + 2;
  endfunction

endpackage

// File: rtl/sdram_cfg_word0.sv
module sdram_cfg_word0
  import sdram_cfg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_hit,
  input  logic             busy,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] word_q,
  output logic             wr_err
);

  logic wr_take;
  logic wr_refuse;

  assign wr_take   = wr_hit && !busy;
  assign wr_refuse = wr_hit && busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= W0_RESET;
      wr_err <= 1'b0;
    end else begin
      if (wr_take)   word_q <= wdata & W0_MASK;
      if (wr_refuse) wr_err <= 1'b1;
    end
  end

endmodule

// File: rtl/sdram_cfg_word1.sv
module sdram_cfg_word1
  import sdram_cfg_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_hit,
  input  logic [W1_BITS-1:0] wdata,
  output logic [W1_BITS-1:0] bits_q,
  output logic               flush_p,
  output logic               nop_p,
  output logic               pall_p
);

  logic      wbuf_fall;
  init_cmd_e new_code;

  assign new_code  = init_cmd_e'(wdata[1:0]);
  assign wbuf_fall = wr_hit && bits_q[B_WBUF] && !wdata[B_WBUF];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bits_q  <= W1_RESET;
      flush_p <= 1'b0;
      nop_p   <= 1'b0;
      pall_p  <= 1'b0;
    end else begin
      if (wr_hit) bits_q <= wdata;
      flush_p <= wbuf_fall;
      nop_p   <= wr_hit && (new_code == INIT_NOP);
      pall_p  <= wr_hit && (new_code == INIT_PALL);
    end
  end

endmodule

// File: rtl/sdram_cfg_regs.sv
module sdram_cfg_regs
  import sdram_cfg_pkg::*;
#(
  parameter int unsigned NUM_CS = 4,
  parameter int unsigned ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              engine_busy,
  output logic [1:0]        ras_lat,
  output logic [1:0]        cas_lat,
  output logic              auto_pchg,
  output logic              cmd_std,
  output logic              bus_half,
  output logic              cke_always,
  output logic              clk_stop,
  output logic              vc_mode,
  output logic [NUM_CS-1:0] cs_four_bank,
  output logic [NUM_CS-1:0] cs_x8,
  output logic              bg_restore_en,
  output logic              wbuf_en,
  output logic              rbuf_en,
  output logic              cmd_mode,
  output logic              wbuf_flush,
  output logic              req_nop,
  output logic              req_pall,
  output logic              cfg_wr_err
);

  localparam logic [ADDR_W-1:0] A_W0 = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_W1 = ADDR_W'(1);

  logic               wr0_hit;
  logic               wr1_hit;
  logic [REG_W-1:0]   word0_q;
  logic [W1_BITS-1:0] word1_q;
  logic [REG_W-1:0]   word1_view;

  assign wr0_hit = reg_we && (reg_addr == A_W0);
  assign wr1_hit = reg_we && (reg_addr == A_W1);

  sdram_cfg_word0 u_word0 (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_hit (wr0_hit),
    .busy   (engine_busy),
    .wdata  (reg_wdata),
    .word_q (word0_q),
    .wr_err (cfg_wr_err)
  );

  sdram_cfg_word1 u_word1 (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_hit  (wr1_hit),
    .wdata   (reg_wdata[W1_BITS-1:0]),
    .bits_q  (word1_q),
    .flush_p (wbuf_flush),
    .nop_p   (req_nop),
    .pall_p  (req_pall)
  );

  // word 0 decode
  assign ras_lat    = lat_cycles(word0_q[B_RC_HI -: 2]);
  assign cas_lat    = lat_cycles(word0_q[B_CL_HI -: 2]);
  assign cmd_std    = word0_q[B_STD];
  assign auto_pchg  = word0_q[B_APCH];
  assign bus_half   = word0_q[B_HALF];
  assign cke_always = word0_q[B_CKE];
  assign clk_stop   = word0_q[B_CSTOP];
  assign vc_mode    = word0_q[B_VC];

  for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
    assign cs_four_bank[i] = word0_q[bank_bit(i)];
    assign cs_x8[i]        = word0_q[mode_bit(i)];
  end

  // word 1 decode
  assign bg_restore_en = word1_q[B_BGR];
  assign wbuf_en       = word1_q[B_WBUF];
  assign rbuf_en       = word1_q[B_RBUF];
  assign cmd_mode      = (init_cmd_e'(word1_q[1:0]) == INIT_CMDMODE);

  assign word1_view = {{(REG_W-B_BUSY-1){1'b0}}, engine_busy, word1_q};

  always_comb begin
    unique case (reg_addr)
      A_W0:    reg_rdata = word0_q;
      A_W1:    reg_rdata = word1_view;
      default: reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/sdram_cfg_regs_chk.sv
module sdram_cfg_regs_chk #(
  parameter int unsigned NUM_CS = 4,
  parameter int unsigned ADDR_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_we,
  input logic [1:0]        init_wr,
  input logic [31:0]       reg_rdata,
  input logic              engine_busy,
  input logic [1:0]        ras_lat,
  input logic [1:0]        cas_lat,
  input logic [NUM_CS-1:0] cs_four_bank,
  input logic [NUM_CS-1:0] cs_x8,
  input logic              auto_pchg,
  input logic              wbuf_en,
  input logic              wbuf_flush,
  input logic              req_nop,
  input logic              req_pall,
  input logic              cfg_wr_err
);

  assert_lat_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_lat != 2'd0) && (cas_lat != 2'd0));

  assert_w0_reserved_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_W'(0)) |-> ((reg_rdata & 32'hFC00_3333) == 32'h0));

  assert_busy_view_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_W'(1)) |->
      ((reg_rdata & 32'hFFFF_FFE0) == {26'b0, engine_busy, 5'b0}));

  assert_busy_write_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == ADDR_W'(0) && engine_busy) |=>
      ($stable(ras_lat) && $stable(cas_lat) && $stable(cs_four_bank) &&
       $stable(cs_x8) && $stable(auto_pchg)));

  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr_err |=> cfg_wr_err);

  assert_flush_on_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wbuf_flush |-> (!wbuf_en && $past(wbuf_en)));

  assert_nop_after_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_nop |-> $past(reg_we && reg_addr == ADDR_W'(1) && init_wr == 2'b11));

  assert_pall_after_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_pall |-> $past(reg_we && reg_addr == ADDR_W'(1) && init_wr == 2'b01));

  assert_init_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({req_nop, req_pall}));

endmodule

bind sdram_cfg_regs sdram_cfg_regs_chk #(
  .NUM_CS (NUM_CS),
  .ADDR_W (ADDR_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .reg_addr     (reg_addr),
  .reg_we       (reg_we),
  .init_wr      (reg_wdata[1:0]),
  .reg_rdata    (reg_rdata),
  .engine_busy  (engine_busy),
  .ras_lat      (ras_lat),
  .cas_lat      (cas_lat),
  .cs_four_bank (cs_four_bank),
  .cs_x8        (cs_x8),
  .auto_pchg    (auto_pchg),
  .wbuf_en      (wbuf_en),
  .wbuf_flush   (wbuf_flush),
  .req_nop      (req_nop),
  .req_pall     (req_pall),
  .cfg_wr_err   (cfg_wr_err)
);

// File: tb/tb_sdram_cfg_regs.sv
module tb_sdram_cfg_regs;
  localparam int CLK_PERIOD = 10;
  localparam int NCS = 4;
  localparam int AW  = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic          reg_we = 1'b0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic          engine_busy = 1'b0;
  logic [1:0]    ras_lat, cas_lat;
  logic          auto_pchg, cmd_std, bus_half, cke_always, clk_stop, vc_mode;
  logic [NCS-1:0] cs_four_bank, cs_x8;
  logic          bg_restore_en, wbuf_en, rbuf_en, cmd_mode;
  logic          wbuf_flush, req_nop, req_pall, cfg_wr_err;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_cfg_regs #(.NUM_CS(NCS), .ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .engine_busy(engine_busy),
    .ras_lat(ras_lat), .cas_lat(cas_lat), .auto_pchg(auto_pchg),
    .cmd_std(cmd_std), .bus_half(bus_half), .cke_always(cke_always),
    .clk_stop(clk_stop), .vc_mode(vc_mode), .cs_four_bank(cs_four_bank),
    .cs_x8(cs_x8), .bg_restore_en(bg_restore_en), .wbuf_en(wbuf_en),
    .rbuf_en(rbuf_en), .cmd_mode(cmd_mode), .wbuf_flush(wbuf_flush),
    .req_nop(req_nop), .req_pall(req_pall), .cfg_wr_err(cfg_wr_err)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive at negedge, returns at the negedge after the capturing edge
  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(0, d); check("R1 word0", d, 32'h01F0_0000);
    rd(1, d); check("R1 word1", d, 32'h0000_0018);
    check("R1 lat", {ras_lat, cas_lat}, {2'd3, 2'd3});
    check("R1 flags", {auto_pchg, wbuf_en, bg_restore_en, rbuf_en, cmd_std, bus_half,
                       cke_always, clk_stop, vc_mode, cmd_mode},
          10'b1110000000);
    check("R1 cs", {cs_four_bank, cs_x8}, 8'h00);
    check("R1 pulses", {wbuf_flush, req_nop, req_pall, cfg_wr_err}, 4'b0000);
  endtask

  task automatic t_latency;
    logic [31:0] d;
    wr(0, 32'h0060_0000);                        // ras 01, cas 10
    check("R2 codes 01/10", {ras_lat, cas_lat}, {2'd1, 2'd2});
    wr(0, 32'h00B0_0000);                        // ras 10, cas 11
    check("R2 codes 10/11", {ras_lat, cas_lat}, {2'd2, 2'd3});
    wr(0, 32'h0000_0000);                        // both reserved
    check("R2 reserved decodes 3", {ras_lat, cas_lat}, {2'd3, 2'd3});
    rd(0, d); check("R2 reserved reads 00", d[23:20], 4'h0);
  endtask

  task automatic t_cs_bits;
    wr(0, 32'h0000_4804);                        // bank cs2 (bit 11), x8 cs3 (bit 14), cs0 (bit 2)
    check("R3 bank", cs_four_bank, 4'b0100);
    check("R3 mode", cs_x8, 4'b1001);
    wr(0, 32'h0000_8088);                        // bank cs3, cs1, cs0
    check("R3 bank2", {cs_four_bank, cs_x8}, {4'b1011, 4'b0000});
  endtask

  task automatic t_flags;
    wr(0, 32'h020A_0000);                        // 25, 19, 17
    check("R4 flags a", {cmd_std, auto_pchg, bus_half, cke_always, clk_stop, vc_mode},
          6'b101010);
    wr(0, 32'h0105_0000);                        // 24, 18, 16
    check("R4 flags b", {cmd_std, auto_pchg, bus_half, cke_always, clk_stop, vc_mode},
          6'b010101);
  endtask

  task automatic t_reserved;
    logic [31:0] d;
    wr(0, 32'hFFFF_FFFF);
    rd(0, d); check("R5 word0 mask", d, 32'h03FF_CCCC);
    wr(1, 32'hFFFF_FFF8);                        // keeps bit3 set, init 00
    rd(1, d); check("R5 word1 mask", d, 32'h0000_0018);
    check("R5 no flush", wbuf_flush, 1'b0);
  endtask

  task automatic t_busy;
    logic [31:0] d;
    wr(0, 32'h0055_0000);
    engine_busy = 1'b1;
    rd(1, d); check("R6 busy reads 1", d[5], 1'b1);
    wr(1, 32'h0000_0018);
    rd(1, d); check("R6 bit5 tracks busy", d, 32'h0000_0038);
    check("R7 err clear", cfg_wr_err, 1'b0);
    wr(0, 32'h00F0_0000);
    rd(0, d); check("R7 busy write ignored", d, 32'h0055_0000);
    check("R7 err set", cfg_wr_err, 1'b1);
    engine_busy = 1'b0;
    rd(1, d); check("R6 busy reads 0", d[5], 1'b0);
    wr(0, 32'h00F0_0000);
    rd(0, d); check("R7 idle write taken", d, 32'h00F0_0000);
    check("R7 err sticky", cfg_wr_err, 1'b1);
  endtask

  task automatic t_enables;
    engine_busy = 1'b1;
    wr(1, 32'h0000_0004);                        // read buffer only, write buffer off
    check("R8 enables", {bg_restore_en, wbuf_en, rbuf_en}, 3'b001);
    check("R9 flush pulse", wbuf_flush, 1'b1);
    engine_busy = 1'b0;
    @(negedge clk);
    check("R9 flush one cycle", wbuf_flush, 1'b0);
    wr(1, 32'h0000_0010);
    check("R9 no flush when already off", wbuf_flush, 1'b0);
    check("R8 enables b", {bg_restore_en, wbuf_en, rbuf_en}, 3'b100);
    wr(1, 32'h0000_0008);
    check("R9 no flush on enable", wbuf_flush, 1'b0);
    wr(1, 32'h0000_0000);
    check("R9 flush again", wbuf_flush, 1'b1);
    wr(1, 32'h0000_0018);
  endtask

  task automatic t_init;
    wr(1, 32'h0000_001B);
    check("R10 nop", {req_nop, req_pall, cmd_mode}, 3'b100);
    @(negedge clk);
    check("R10 nop one cycle", {req_nop, req_pall}, 2'b00);
    wr(1, 32'h0000_001B);
    check("R10 nop repeat", req_nop, 1'b1);
    wr(1, 32'h0000_0019);
    check("R10 pall", {req_nop, req_pall, cmd_mode}, 3'b010);
    @(negedge clk);
    check("R10 pall one cycle", req_pall, 1'b0);
    wr(1, 32'h0000_001A);
    check("R10 cmd mode", {req_nop, req_pall, cmd_mode}, 3'b001);
    repeat (3) @(negedge clk);
    check("R10 cmd mode held", cmd_mode, 1'b1);
    wr(1, 32'h0000_0018);
    check("R10 normal", {req_nop, req_pall, cmd_mode}, 3'b000);
  endtask

  task automatic t_unmapped;
    logic [31:0] d;
    wr(0, 32'h0123_4444);
    wr(2, 32'hFFFF_FFFF);
    wr(3, 32'h0000_0000);
    rd(0, d); check("R11 word0 untouched", d, 32'h0123_4444);
    rd(1, d); check("R11 word1 untouched", d, 32'h0000_0018);
    check("R11 no pulse", {wbuf_flush, req_nop, req_pall}, 3'b000);
    rd(2, d); check("R11 read 2", d, 32'h0);
    rd(3, d); check("R11 read 3", d, 32'h0);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_latency();
    t_cs_bits();
    t_flags();
    t_reserved();
    t_busy();
    t_enables();
    t_init();
    t_unmapped();
    finish_run();
  end

endmodule